// File: doc/BRIEF.md
# Processor Power Mode Manager

This block steps a processor between three operating modes: full run, a light idle mode and a deep sleep mode. In idle only the processor clock is gated. Timers, interrupt logic and I/O stay powered and clocked, and any interrupt that is both pending and enabled brings the core back to run. Sleep goes much further. The core clock is stopped, the core is held in reset, and then the external supply-enable pin is dropped so that the board regulator can turn the core supply off. The crystal oscillator is turned off at the same time.

The manager itself runs on an always-on clock. It advances its timed waits on a qualifying pulse from a low-speed time base. Every step of the idle and sleep sequences waits for its own programmable number of low-speed ticks before the next step starts. Each wait uses a down-counter that is loaded when the step begins and is released when it reaches zero.

Wake-up from sleep runs in a fixed order:
1. Raise the supply enable and wait for the rail.
2. Enable the oscillator and wait for it to settle.
3. Release the core reset so that boot can begin.

A wake event that arrives while sleep entry is still in progress is remembered. Wake-up then starts as soon as the power-down has finished.

Top module: `pwr_mode_mgr`

## Requirements
- R1: While reset is applied and right after it is released, the block is in run: cpu_clk_en=1, cpu_rst=0, pwr_en=1, osc_en=1, ready=1, cur_mode=2'b00.
- R2: A one-cycle idle request in run starts an idle entry step (cur_mode=2'b11, clock still enabled) lasting dly_idle_in ticks. After it, cur_mode=2'b01 and cpu_clk_en=0, while pwr_en=1, osc_en=1 and cpu_rst=0 are kept.
- R3: In idle, only a wake source with irq_pend[i]=1 and irq_en[i]=1 for some i starts the exit. A pending source whose enable bit is 0 is ignored. The exit step lasts dly_idle_out ticks, with the clock still off, and then returns to run.
- R4: Sleep entry order is as follows. First the clock stops, with reset low, for dly_halt ticks. Then cpu_rst rises and is held for dly_rst ticks. Then pwr_en and osc_en fall together, and cur_mode=2'b10.
- R5: Wake-up order is as follows. First pwr_en rises alone for dly_pwr ticks. Then osc_en rises for dly_osc ticks. Then cpu_rst falls together with cpu_clk_en rising, and ready=1.
- R6: Every wait counts only cycles where slow_tick=1. A count of N lets the step end on the cycle after the N-th tick, and a count of 0 ends the step after one cycle.
- R7: A sleep request seen while an enabled wake source is pending is dropped, and the block stays in run.
- R8: A wake event seen during either sleep entry step is remembered even if it is a one-cycle pulse. The block still reaches sleep, and then goes straight into wake-up.
- R9: ready is 1 only in run with reset released. cur_mode reports 2'b00 in run, 2'b01 in idle, 2'b10 in sleep and 2'b11 in every timed transition step.
- R10: When idle and sleep requests arrive in the same cycle, sleep wins.
- R11: Idle and sleep requests made outside run have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on manager clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle pulse from the low-speed time base |
| req_idle | input | 1 | Software request to enter idle |
| req_sleep | input | 1 | Software request to enter sleep |
| irq_pend | input | IRQ_N | Pending wake and interrupt sources |
| irq_en | input | IRQ_N | Enable mask for the wake sources |
| dly_idle_in | input | CNT_W | Ticks for the idle entry step |
| dly_idle_out | input | CNT_W | Ticks for the idle exit step |
| dly_halt | input | CNT_W | Ticks between clock stop and reset assertion |
| dly_rst | input | CNT_W | Ticks between reset assertion and power-off |
| dly_pwr | input | CNT_W | Ticks for the supply to come up |
| dly_osc | input | CNT_W | Ticks for the oscillator to settle |
| cpu_clk_en | output | 1 | Core clock enable |
| cpu_rst | output | 1 | Core reset, active high |
| pwr_en | output | 1 | External supply enable pin |
| osc_en | output | 1 | Oscillator enable |
| ready | output | 1 | Core running with reset released |
| cur_mode | output | 2 | Current mode code |

## Verification
Two events can fall in the same cycle and are provoked on purpose.

The first is a wake event arriving during the cycle that decides on a sleep request. The bench holds an enabled source pending while it pulses the sleep request, and expects the block to remain in run with ready high.

The second is a wake pulse landing inside the timed sleep entry. The bench fires a single-cycle wake while the clock-stop wait is still counting, and requires both that cur_mode passes through the sleep code and that the block returns to run on its own.

A behavioural model in the bench predicts every output on every clock, so the exact cycle on which each step ends is judged as well.

// File: rtl/pmm_pkg.sv
package pmm_pkg;

   // sequencer states; each timed step owns one code
   typedef enum logic [3:0] {
      ST_RUN      = 4'd0,
      ST_IDLE_ENT = 4'd1,
      ST_IDLE     = 4'd2,
      ST_IDLE_EXT = 4'd3,
      ST_HALT     = 4'd4,
      ST_RST_HOLD = 4'd5,
      ST_SLEEP    = 4'd6,
      ST_PWR_UP   = 4'd7,
      ST_OSC_UP   = 4'd8
   } pmm_state_e;

   localparam logic [1:0] MODE_RUN   = 2'b00;
   localparam logic [1:0] MODE_IDLE  = 2'b01;
   localparam logic [1:0] MODE_SLEEP = 2'b10;
   localparam logic [1:0] MODE_MOVE  = 2'b11;

   typedef struct packed {
      logic       clk_en;
      logic       cpu_rst;
      logic       pwr_en;
      logic       osc_en;
      logic       ready;
      logic [1:0] mode;
   } pmm_ctl_t;

endpackage

// File: rtl/pmm_wait_timer.sv
module pmm_wait_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   initial begin
      assert (CNT_W >= 2 && CNT_W <= 32)
         else $error("pmm_wait_timer: CNT_W out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (tick && (cnt_q != '0))
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

   // R6
   hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !tick) |=> $stable(cnt_q));

   // R6
   load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/pmm_seq_fsm.sv
module pmm_seq_fsm
   import pmm_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_idle,
   input  logic             req_sleep,
   input  logic             wake,
   input  logic             wait_done,
   input  logic [CNT_W-1:0] dly_idle_in,
   input  logic [CNT_W-1:0] dly_idle_out,
   input  logic [CNT_W-1:0] dly_halt,
   input  logic [CNT_W-1:0] dly_rst,
   input  logic [CNT_W-1:0] dly_pwr,
   input  logic [CNT_W-1:0] dly_osc,
   output pmm_state_e       state,
   output logic             load,
   output logic [CNT_W-1:0] load_val
);

   pmm_state_e state_q, state_d;
   logic       wake_hold_q, wake_hold_d;
   logic       nxt_timed;

   always_comb begin
      state_d     = state_q;
      wake_hold_d = wake_hold_q;
      unique case (state_q)
         ST_RUN: begin
            wake_hold_d = 1'b0;
            if (req_sleep) begin
               if (!wake) state_d = ST_HALT;
            end else if (req_idle) begin
               state_d = ST_IDLE_ENT;
            end
         end
         ST_IDLE_ENT: begin
            wake_hold_d = wake_hold_q | wake;
            if (wait_done) state_d = ST_IDLE;
         end
         ST_IDLE: begin
            if (wake || wake_hold_q) begin
               state_d     = ST_IDLE_EXT;
               wake_hold_d = 1'b0;
            end
         end
         ST_IDLE_EXT: begin
            if (wait_done) state_d = ST_RUN;
         end
         ST_HALT: begin
            wake_hold_d = wake_hold_q | wake;
            if (wait_done) state_d = ST_RST_HOLD;
         end
         ST_RST_HOLD: begin
            wake_hold_d = wake_hold_q | wake;
            if (wait_done) state_d = ST_SLEEP;
         end
         ST_SLEEP: begin
            if (wake || wake_hold_q) begin
               state_d     = ST_PWR_UP;
               wake_hold_d = 1'b0;
            end
         end
         ST_PWR_UP: begin
            if (wait_done) state_d = ST_OSC_UP;
         end
         ST_OSC_UP: begin
            if (wait_done) state_d = ST_RUN;
         end
         default: begin
            state_d     = ST_RUN;
            wake_hold_d = 1'b0;
         end
      endcase
   end

   // wait length picked by the step being entered
   always_comb begin
      nxt_timed = 1'b1;
      load_val  = '0;
      unique case (state_d)
         ST_IDLE_ENT: load_val = dly_idle_in;
         ST_IDLE_EXT: load_val = dly_idle_out;
         ST_HALT:     load_val = dly_halt;
         ST_RST_HOLD: load_val = dly_rst;
         ST_PWR_UP:   load_val = dly_pwr;
         ST_OSC_UP:   load_val = dly_osc;
         default:     nxt_timed = 1'b0;
      endcase
   end

   assign load  = nxt_timed && (state_d != state_q);
   assign state = state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_RUN;
         wake_hold_q <= 1'b0;
      end else begin
         state_q     <= state_d;
         wake_hold_q <= wake_hold_d;
      end
   end

   // R7
   abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && req_sleep && wake) |=> (state_q == ST_RUN));

   // R10
   sleep_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && req_sleep && req_idle && !wake) |=> (state_q == ST_HALT));

   // R8
   held_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RST_HOLD && wait_done && (wake || wake_hold_q))
      |=> (state_q == ST_SLEEP && wake_hold_q));

   // R11
   sleep_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SLEEP && !wake && !wake_hold_q) |=> (state_q == ST_SLEEP));

endmodule

// File: rtl/pmm_out_decode.sv
module pmm_out_decode
   import pmm_pkg::*;
(
   input  pmm_state_e state,
   output pmm_ctl_t   ctl
);

   always_comb begin
      ctl = '{clk_en: 1'b0, cpu_rst: 1'b1, pwr_en: 1'b1, osc_en: 1'b1,
              ready: 1'b0, mode: MODE_MOVE};
      unique case (state)
         ST_RUN: begin
            ctl.clk_en  = 1'b1;
            ctl.cpu_rst = 1'b0;
            ctl.ready   = 1'b1;
            ctl.mode    = MODE_RUN;
         end
         ST_IDLE_ENT: begin
            ctl.clk_en  = 1'b1;
            ctl.cpu_rst = 1'b0;
         end
         ST_IDLE: begin
            ctl.cpu_rst = 1'b0;
            ctl.mode    = MODE_IDLE;
         end
         ST_IDLE_EXT, ST_HALT: begin
            ctl.cpu_rst = 1'b0;
         end
         ST_RST_HOLD, ST_OSC_UP: begin
         end
         ST_SLEEP: begin
            ctl.pwr_en = 1'b0;
            ctl.osc_en = 1'b0;
            ctl.mode   = MODE_SLEEP;
         end
         ST_PWR_UP: begin
            ctl.osc_en = 1'b0;
         end
         default: begin
         end
      endcase
   end

endmodule

// File: rtl/pwr_mode_mgr.sv
module pwr_mode_mgr
   import pmm_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int IRQ_N       = 4,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slow_tick,
   input  logic             req_idle,
   input  logic             req_sleep,
   input  logic [IRQ_N-1:0] irq_pend,
   input  logic [IRQ_N-1:0] irq_en,
   input  logic [CNT_W-1:0] dly_idle_in,
   input  logic [CNT_W-1:0] dly_idle_out,
   input  logic [CNT_W-1:0] dly_halt,
   input  logic [CNT_W-1:0] dly_rst,
   input  logic [CNT_W-1:0] dly_pwr,
   input  logic [CNT_W-1:0] dly_osc,
   output logic             cpu_clk_en,
   output logic             cpu_rst,
   output logic             pwr_en,
   output logic             osc_en,
   output logic             ready,
   output logic [1:0]       cur_mode
);

   initial begin
      assert (IRQ_N >= 1 && IRQ_N <= 64)
         else $error("pwr_mode_mgr: IRQ_N out of range");
      assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 4)
         else $error("pwr_mode_mgr: SYNC_STAGES out of range");
   end

   logic [IRQ_N-1:0] irq_seen;
   logic [IRQ_N-1:0] irq_hit;
   logic             wake;
   logic             load, wait_done;
   logic [CNT_W-1:0] load_val;
   pmm_state_e       state;
   pmm_ctl_t         ctl;

   // optional resync of wake sources arriving from other domains
   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign irq_seen = irq_pend;
      end else begin : g_sync
         logic [IRQ_N-1:0] chain_q [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < SYNC_STAGES; k++) chain_q[k] <= '0;
            end else begin
               chain_q[0] <= irq_pend;
               for (int k = 1; k < SYNC_STAGES; k++) chain_q[k] <= chain_q[k-1];
            end
         end
         assign irq_seen = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   for (genvar i = 0; i < IRQ_N; i++) begin : g_mask
      assign irq_hit[i] = irq_seen[i] & irq_en[i];
   end
   assign wake = |irq_hit;

   pmm_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_idle     (req_idle),
      .req_sleep    (req_sleep),
      .wake         (wake),
      .wait_done    (wait_done),
      .dly_idle_in  (dly_idle_in),
      .dly_idle_out (dly_idle_out),
      .dly_halt     (dly_halt),
      .dly_rst      (dly_rst),
      .dly_pwr      (dly_pwr),
      .dly_osc      (dly_osc),
      .state        (state),
      .load         (load),
      .load_val     (load_val)
   );

   pmm_wait_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .tick     (slow_tick),
      .done     (wait_done)
   );

   pmm_out_decode u_dec (
      .state (state),
      .ctl   (ctl)
   );

   assign cpu_clk_en = ctl.clk_en;
   assign cpu_rst    = ctl.cpu_rst;
   assign pwr_en     = ctl.pwr_en;
   assign osc_en     = ctl.osc_en;
   assign ready      = ctl.ready;
   assign cur_mode   = ctl.mode;

   // R4
   pwr_off_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_en) |-> ($past(cpu_rst) && !cpu_clk_en));

   // R4
   rst_after_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_rst) |-> ($past(!cpu_clk_en) && pwr_en));

   // R5
   osc_after_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(osc_en) |-> $past(pwr_en));

   // R5
   rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_rst) |-> ($past(osc_en) && pwr_en && cpu_clk_en));

   // R9
   ready_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (cpu_clk_en && !cpu_rst && cur_mode == MODE_RUN));

endmodule

// File: tb/pwr_mode_mgr_tb.sv
`timescale 1ns/1ps
module pwr_mode_mgr_tb;

   localparam int CW = 16;
   localparam int NI = 4;

   localparam int M_RUN = 0, M_IENT = 1, M_IDLE = 2, M_IEXT = 3, M_HALT = 4,
                  M_RHLD = 5, M_SLP = 6, M_PUP = 7, M_OUP = 8;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          slow_tick = 1'b0;
   logic          req_idle = 1'b0, req_sleep = 1'b0;
   logic [NI-1:0] irq_pend = '0, irq_en = '0;
   logic [CW-1:0] dly_idle_in = 16'd2, dly_idle_out = 16'd3, dly_halt = 16'd2;
   logic [CW-1:0] dly_rst = 16'd3, dly_pwr = 16'd5, dly_osc = 16'd4;
   logic          cpu_clk_en, cpu_rst, pwr_en, osc_en, ready;
   logic [1:0]    cur_mode;

   pwr_mode_mgr #(.CNT_W(CW), .IRQ_N(NI)) u_dut (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
      .req_idle(req_idle), .req_sleep(req_sleep),
      .irq_pend(irq_pend), .irq_en(irq_en),
      .dly_idle_in(dly_idle_in), .dly_idle_out(dly_idle_out),
      .dly_halt(dly_halt), .dly_rst(dly_rst), .dly_pwr(dly_pwr), .dly_osc(dly_osc),
      .cpu_clk_en(cpu_clk_en), .cpu_rst(cpu_rst), .pwr_en(pwr_en),
      .osc_en(osc_en), .ready(ready), .cur_mode(cur_mode)
   );

   int checks = 0;
   int errors = 0;
   bit cmp_on = 1'b0;

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // expected pin vector {clk_en, rst, pwr, osc, ready, mode[1:0]}
   function automatic int m_vec(int s);
      case (s)
         M_RUN:  return 7'b1011100;
         M_IENT: return 7'b1011011;
         M_IDLE: return 7'b0011001;
         M_IEXT: return 7'b0011011;
         M_HALT: return 7'b0011011;
         M_RHLD: return 7'b0111011;
         M_SLP:  return 7'b0100010;
         M_PUP:  return 7'b0110011;
         default: return 7'b0111011;
      endcase
   endfunction

   // low-speed tick source
   int  tick_div = 3;
   bit  tick_off = 1'b0;
   int  tcnt = 0;
   always @(negedge clk) begin
      tcnt++;
      slow_tick <= !tick_off && ((tcnt % tick_div) == 0);
   end

   // behavioural reference model
   int m_st = M_RUN, m_cnt = 0, ns, nc;
   bit m_lat = 1'b0, nl, wk, dn;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = M_RUN; m_cnt = 0; m_lat = 1'b0;
      end else begin
         wk = |(irq_pend & irq_en);
         dn = (m_cnt == 0);
         ns = m_st; nl = m_lat;
         nc = (slow_tick && m_cnt > 0) ? m_cnt - 1 : m_cnt;
         case (m_st)
            M_RUN: begin
               if (req_sleep) begin
                  if (!wk) begin ns = M_HALT; nc = int'(dly_halt); end
               end else if (req_idle) begin
                  ns = M_IENT; nc = int'(dly_idle_in);
               end
            end
            M_IENT: begin nl = m_lat | wk; if (dn) ns = M_IDLE; end
            M_IDLE: if (wk || m_lat) begin ns = M_IEXT; nc = int'(dly_idle_out); nl = 1'b0; end
            M_IEXT: if (dn) ns = M_RUN;
            M_HALT: begin nl = m_lat | wk; if (dn) begin ns = M_RHLD; nc = int'(dly_rst); end end
            M_RHLD: begin nl = m_lat | wk; if (dn) ns = M_SLP; end
            M_SLP:  if (wk || m_lat) begin ns = M_PUP; nc = int'(dly_pwr); nl = 1'b0; end
            M_PUP:  if (dn) begin ns = M_OUP; nc = int'(dly_osc); end
            default: if (dn) ns = M_RUN;
         endcase
         m_st = ns; m_cnt = nc; m_lat = nl;
      end
   end

   // every-cycle comparison (R6 timing, R9 encoding)
   always @(negedge clk) begin
      if (cmp_on)
         chk("R6/R9 model compare", int'({cpu_clk_en, cpu_rst, pwr_en, osc_en, ready, cur_mode}), m_vec(m_st));
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic pulse_req(bit idle, bit slp);
      @(negedge clk); req_idle = idle; req_sleep = slp;
      @(negedge clk); req_idle = 1'b0; req_sleep = 1'b0;
   endtask

   task automatic pulse_irq(logic [NI-1:0] v);
      @(negedge clk); irq_pend = v;
      @(negedge clk); irq_pend = '0;
   endtask

   task automatic wait_mode(logic [1:0] m, string tag);
      int n = 0;
      while (cur_mode !== m && n < 3000) begin @(negedge clk); n++; end
      chk(tag, int'(cur_mode), int'(m));
   endtask

   initial begin
      irq_en = 4'b0001;
      repeat (3) @(negedge clk);
      chk("R1 reset clk_en/rst/pwr/osc", int'({cpu_clk_en, cpu_rst, pwr_en, osc_en}), 4'b1011);
      chk("R1 reset ready", int'(ready), 1);
      chk("R1 reset mode", int'(cur_mode), 0);
      rst_n = 1'b1;
      @(negedge clk);
      cmp_on = 1'b1;
      chk("R1 after release ready", int'(ready), 1);

      // idle entry and exit
      pulse_req(1'b1, 1'b0);
      chk("R2 entry step keeps clock", int'({cpu_clk_en, cur_mode}), 3'b111);
      wait_mode(2'b01, "R2 idle reached");
      chk("R2 idle clock gated", int'(cpu_clk_en), 0);
      chk("R2 idle keeps power/osc/no reset", int'({pwr_en, osc_en, cpu_rst}), 3'b110);
      irq_pend = 4'b0010;
      repeat (30) @(negedge clk);
      chk("R3 masked irq ignored", int'(cur_mode), 1);
      irq_pend = '0;
      pulse_req(1'b0, 1'b1);
      chk("R11 sleep request in idle ignored", int'(cur_mode), 1);
      pulse_irq(4'b0001);
      wait_mode(2'b00, "R3 enabled irq returns to run");
      chk("R9 ready in run", int'(ready), 1);

      // full sleep cycle
      pulse_req(1'b0, 1'b1);
      begin
         int n = 0;
         while (cpu_rst !== 1'b1 && n < 3000) begin @(negedge clk); n++; end
      end
      chk("R4 reset asserted while power on", int'({cpu_rst, pwr_en, cpu_clk_en}), 3'b110);
      wait_mode(2'b10, "R4 sleep reached");
      chk("R4 sleep pins", int'({pwr_en, osc_en, cpu_rst}), 3'b001);
      pulse_req(1'b1, 1'b1);
      repeat (20) @(negedge clk);
      chk("R11 requests in sleep ignored", int'(cur_mode), 2);
      pulse_irq(4'b0001);
      chk("R5 power first", int'({pwr_en, osc_en, cpu_rst}), 3'b101);
      begin
         int n = 0;
         while (osc_en !== 1'b1 && n < 3000) begin @(negedge clk); n++; end
      end
      chk("R5 osc before reset release", int'({pwr_en, osc_en, cpu_rst, cpu_clk_en}), 4'b1110);
      wait_mode(2'b00, "R5 back to run");
      chk("R5 ready after boot release", int'({ready, cpu_rst}), 2'b10);

      // abort when wake already pending
      irq_pend = 4'b0001;
      pulse_req(1'b0, 1'b1);
      repeat (10) @(negedge clk);
      chk("R7 sleep aborted mode", int'(cur_mode), 0);
      chk("R7 sleep aborted ready", int'(ready), 1);
      irq_pend = '0;

      // wake pulse during entry is held
      pulse_req(1'b0, 1'b1);
      @(negedge clk);
      pulse_irq(4'b0001);
      begin
         bit saw_sleep = 1'b0;
         int n = 0;
         while (ready !== 1'b1 && n < 3000) begin
            @(negedge clk); n++;
            if (cur_mode === 2'b10) saw_sleep = 1'b1;
         end
         chk("R8 passed through sleep", int'(saw_sleep), 1);
         chk("R8 woke without further event", int'(ready), 1);
      end

      // simultaneous requests
      pulse_req(1'b1, 1'b1);
      begin
         bit saw_idle = 1'b0;
         int n = 0;
         while (cur_mode !== 2'b10 && n < 3000) begin
            @(negedge clk); n++;
            if (cur_mode === 2'b01) saw_idle = 1'b1;
         end
         chk("R10 idle skipped", int'(saw_idle), 0);
         chk("R10 sleep reached", int'(cur_mode), 2);
      end
      pulse_irq(4'b0001);
      wait_mode(2'b00, "R10 run again");

      // waits freeze without ticks
      tick_off = 1'b1;
      pulse_req(1'b1, 1'b0);
      repeat (40) @(negedge clk);
      chk("R6 no tick keeps entry step", int'({cpu_clk_en, cur_mode}), 3'b111);
      tick_off = 1'b0;
      wait_mode(2'b01, "R6 idle after ticks resume");
      pulse_irq(4'b0001);
      wait_mode(2'b00, "R6 run after idle");

      // zero-length waits
      dly_halt = '0; dly_rst = '0; dly_pwr = '0; dly_osc = '0;
      dly_idle_in = '0; dly_idle_out = '0;
      pulse_req(1'b0, 1'b1);
      chk("R6 zero wait halt step", int'({cpu_clk_en, cpu_rst}), 2'b00);
      @(negedge clk);
      chk("R6 zero wait reset step", int'({cpu_rst, pwr_en}), 2'b11);
      @(negedge clk);
      chk("R6 zero wait sleep", int'(cur_mode), 2);
      pulse_irq(4'b0001);
      chk("R6 zero wait power step", int'({pwr_en, osc_en}), 2'b10);
      @(negedge clk);
      chk("R6 zero wait osc step", int'({osc_en, cpu_rst}), 2'b11);
      @(negedge clk);
      chk("R6 zero wait run", int'(ready), 1);

      repeat (5) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule